// File: doc/BRIEF.md
# Two-Stage Noise-Shaper Output Merger

This block is the digital end of a reconfigurable cascade of two second-order, one-bit noise-shaping converter stages. Each stage delivers one bit per sample. In fourth-order operation the block turns both bits into a signed multi-bit word that cancels the quantisation error of the first stage. The first-stage bit is delayed by two samples. The second-stage bit passes through a double difference and is scaled by a gain of five. In second-order operation the first stage is switched off and the block forwards the second-stage bit unchanged.

The block also owns the operating configuration: loop order, sample-clock choice, bandwidth and bias level. A two-bit mode select picks one of three fixed presets or a custom set of fields. The chosen configuration is registered and drives the stage enables and the one-hot clock and bias selects. Any change of the effective configuration wipes the merge history. Outputs stay marked invalid until the history has refilled.

Top module: `ncc_cascade_merge`

## Requirements
- R1: In fourth order, each accepted sample gives dout = y1[n-2] + 5*(y2[n] - 2*y2[n-1] + y2[n-2]) as a two's-complement word of DOUT_W bits. Here a stage bit of 1 maps to +1 and 0 maps to -1, and a history entry cleared by reset or by a configuration change counts as 0. The extremes are +21 and -21.
- R2: In second order, each accepted sample gives dout with bit 0 equal to bit_s2 and all other bits zero.
- R3: dout is registered. dout_vld pulses for one cycle, one clock after an accepted strobe. dout keeps its value in every cycle without an accepted strobe.
- R4: A strobe is ignored in the cycle in which the effective configuration differs from the registered one. That change clears the merge history. The next two accepted strobes update dout but keep dout_vld low, and the third one raises it.
- R5: While reset is asserted, dout is 0, dout_vld is 0 and the configuration is the low-power preset. After reset, the first two strobes are blanked as in R4.
- R6: mode_sel 0 selects the low-power preset: second order, 768 kHz, 4 kHz, 50 % bias. mode_sel 1 selects the standard preset: fourth order, 2.4 MHz, 20 kHz, 75 % bias. mode_sel 2 selects the high-resolution preset: fourth order, 3.6 MHz, 20 kHz, 100 % bias. mode_sel 3 takes the cust_* fields. The control outputs follow one clock after the selects. rate_oh bits 0/1/2 are 768 kHz/2.4 MHz/3.6 MHz. bias_oh bits 0/1/2 are 50/75/100 %. bw_wide=1 means 20 kHz. stg1_en is high only in fourth order. stg2_en is always high.
- R7: In custom mode, cust_order=1 means fourth order. cust_rate and cust_bias codes 0, 1 and 2 select bit 0, 1 and 2 of their one-hot output, and code 3 acts as code 2.
- R8: A change of the select inputs that yields the same effective configuration neither clears the history nor blanks the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| bit_s1 | input | 1 | First-stage bit |
| bit_s2 | input | 1 | Second-stage bit |
| mode_sel | input | 2 | Preset select (0 low-power, 1 standard, 2 high-res, 3 custom) |
| cust_order | input | 1 | Custom loop order, 1 = fourth |
| cust_rate | input | 2 | Custom sample-clock code |
| cust_wide | input | 1 | Custom bandwidth, 1 = 20 kHz |
| cust_bias | input | 2 | Custom bias code |
| dout | output | DOUT_W | Merged signed word or forwarded bit |
| dout_vld | output | 1 | Valid pulse for dout |
| stg1_en | output | 1 | First-stage enable |
| stg2_en | output | 1 | Second-stage enable |
| rate_oh | output | 3 | One-hot sample-clock select |
| bw_wide | output | 1 | Wide bandwidth select |
| bias_oh | output | 3 | One-hot bias select |

## Verification
A configuration change and a sample strobe can arrive on the same clock edge. The bench provokes this by moving mode_sel and raising smp_stb in the same cycle. It then expects the strobe to be dropped, dout to keep its old value and dout_vld to stay low for that strobe and the next two. The opposite case is also covered. The selects move from the standard preset to a custom set equal to it while a strobe arrives, and the result must come out valid with the unbroken history applied.

// File: rtl/ncc_pkg.sv
package ncc_pkg;

   localparam int N_RATE = 3;
   localparam int N_BIAS = 3;

   localparam logic [1:0] MODE_LOW    = 2'd0;
   localparam logic [1:0] MODE_STD    = 2'd1;
   localparam logic [1:0] MODE_HIRES  = 2'd2;
   localparam logic [1:0] MODE_CUSTOM = 2'd3;

   typedef struct packed {
      logic       order4;
      logic [1:0] rate;
      logic       wide;
      logic [1:0] bias;
   } ncc_cfg_t;

   localparam ncc_cfg_t CFG_LOW   = '{order4: 1'b0, rate: 2'd0, wide: 1'b0, bias: 2'd0};
   localparam ncc_cfg_t CFG_STD   = '{order4: 1'b1, rate: 2'd1, wide: 1'b1, bias: 2'd1};
   localparam ncc_cfg_t CFG_HIRES = '{order4: 1'b1, rate: 2'd2, wide: 1'b1, bias: 2'd2};

   // The unused code 3 folds onto the highest legal code.
   function automatic logic [1:0] fold_code(input logic [1:0] c);
      return (c == 2'd3) ? 2'd2 : c;
   endfunction

endpackage

// File: rtl/ncc_mode_map.sv
module ncc_mode_map
   import ncc_pkg::*;
(
   input  logic [1:0] mode_sel,
   input  logic       cust_order,
   input  logic [1:0] cust_rate,
   input  logic       cust_wide,
   input  logic [1:0] cust_bias,
   output ncc_cfg_t   cfg
);

   always_comb begin
      unique case (mode_sel)
         MODE_LOW:   cfg = CFG_LOW;
         MODE_STD:   cfg = CFG_STD;
         MODE_HIRES: cfg = CFG_HIRES;
         default: begin
            cfg.order4 = cust_order;
            cfg.rate   = fold_code(cust_rate);
            cfg.wide   = cust_wide;
            cfg.bias   = fold_code(cust_bias);
         end
      endcase
   end

endmodule

// File: rtl/ncc_ctrl_drive.sv
module ncc_ctrl_drive
   import ncc_pkg::*;
(
   input  ncc_cfg_t          cfg,
   output logic              stg1_en,
   output logic              stg2_en,
   output logic [N_RATE-1:0] rate_oh,
   output logic              bw_wide,
   output logic [N_BIAS-1:0] bias_oh
);

   assign stg1_en = cfg.order4;
   assign stg2_en = 1'b1;
   assign bw_wide = cfg.wide;

   for (genvar i = 0; i < N_RATE; i++) begin : g_rate
      assign rate_oh[i] = (cfg.rate == 2'(i));
   end

   for (genvar j = 0; j < N_BIAS; j++) begin : g_bias
      assign bias_oh[j] = (cfg.bias == 2'(j));
   end

endmodule

// File: rtl/ncc_merge_core.sv
module ncc_merge_core #(
   parameter int DW        = 6,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 adv,
   input  logic                 order4,
   input  logic                 bit_a,
   input  logic                 bit_b,
   output logic signed [DW-1:0] res
);

   localparam int DEPTH = 2;
   localparam logic signed [DW-1:0] GAIN = DW'(5);

   logic signed [1:0]    y1, y2;
   logic signed [1:0]    h1 [DEPTH];
   logic signed [1:0]    h2 [DEPTH];
   logic signed [DW-1:0] diff, scaled;

   function automatic logic signed [DW-1:0] sx(input logic signed [1:0] v);
      return {{(DW-2){v[1]}}, v};
   endfunction

   assign y1 = bit_a ? 2'sd1 : -2'sd1;
   assign y2 = bit_b ? 2'sd1 : -2'sd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            h1[i] <= '0;
            h2[i] <= '0;
         end
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) begin
            h1[i] <= '0;
            h2[i] <= '0;
         end
      end else if (adv && order4) begin
         h1[0] <= y1;
         h2[0] <= y2;
         for (int i = 1; i < DEPTH; i++) begin
            h1[i] <= h1[i-1];
            h2[i] <= h2[i-1];
         end
      end
   end

   assign diff = sx(y2) - (sx(h2[0]) <<< 1) + sx(h2[DEPTH-1]);

   if (SHIFT_ADD) begin : g_shift_add
      assign scaled = (diff <<< 2) + diff;
   end else begin : g_mult
      assign scaled = diff * GAIN;
   end

   assign res = order4 ? (sx(h1[DEPTH-1]) + scaled) : {{(DW-1){1'b0}}, bit_b};

   // R4: a clear leaves the whole history at zero on the next cycle
   p_hist_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (h1[0] == 2'sd0 && h1[1] == 2'sd0 && h2[0] == 2'sd0 && h2[1] == 2'sd0));

   // R1: the merged word never leaves the +/-21 span
   p_res_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
      order4 |-> (res <= 21 && res >= -21));

endmodule

// File: rtl/ncc_cascade_merge.sv
module ncc_cascade_merge
   import ncc_pkg::*;
#(
   parameter int DOUT_W    = 6,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_stb,
   input  logic                     bit_s1,
   input  logic                     bit_s2,
   input  logic [1:0]               mode_sel,
   input  logic                     cust_order,
   input  logic [1:0]               cust_rate,
   input  logic                     cust_wide,
   input  logic [1:0]               cust_bias,
   output logic signed [DOUT_W-1:0] dout,
   output logic                     dout_vld,
   output logic                     stg1_en,
   output logic                     stg2_en,
   output logic [N_RATE-1:0]        rate_oh,
   output logic                     bw_wide,
   output logic [N_BIAS-1:0]        bias_oh
);

   localparam int BLANK_N = 2;
   localparam int BLANK_W = $clog2(BLANK_N + 1);

   if (DOUT_W < 6) begin : g_width_check
      $error("DOUT_W must be at least 6 to hold +/-21");
   end

   ncc_cfg_t                 cfg_d, cfg_q;
   logic                     chg, take;
   logic [BLANK_W-1:0]       blank_q;
   logic signed [DOUT_W-1:0] res;

   ncc_mode_map u_map (
      .mode_sel   (mode_sel),
      .cust_order (cust_order),
      .cust_rate  (cust_rate),
      .cust_wide  (cust_wide),
      .cust_bias  (cust_bias),
      .cfg        (cfg_d)
   );

   assign chg  = (cfg_d != cfg_q);
   assign take = smp_stb && !chg;

   ncc_merge_core #(.DW(DOUT_W), .SHIFT_ADD(SHIFT_ADD)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (chg),
      .adv    (take),
      .order4 (cfg_q.order4),
      .bit_a  (bit_s1),
      .bit_b  (bit_s2),
      .res    (res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q    <= CFG_LOW;
         blank_q  <= BLANK_W'(BLANK_N);
         dout     <= '0;
         dout_vld <= 1'b0;
      end else begin
         cfg_q    <= cfg_d;
         dout_vld <= 1'b0;
         if (chg) begin
            blank_q <= BLANK_W'(BLANK_N);
         end else if (smp_stb) begin
            dout <= res;
            if (blank_q != '0) blank_q <= blank_q - 1'b1;
            else               dout_vld <= 1'b1;
         end
      end
   end

   ncc_ctrl_drive u_ctrl (
      .cfg     (cfg_q),
      .stg1_en (stg1_en),
      .stg2_en (stg2_en),
      .rate_oh (rate_oh),
      .bw_wide (bw_wide),
      .bias_oh (bias_oh)
   );

   // R3: valid only follows a strobe
   p_vld_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dout_vld |-> $past(smp_stb));

   // R3: without a strobe the word holds
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(dout));

   // R4: a configuration change blanks the following cycle
   p_chg_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !dout_vld);

   // R2: second-order words carry the stage bit alone
   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_vld && !stg1_en) |-> (dout[0] == $past(bit_s2) && dout[DOUT_W-1:1] == '0));

   // R6: control selects stay one-hot and the second stage stays on
   p_ctrl_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(rate_oh) == 1 && $countones(bias_oh) == 1 && stg2_en));

endmodule

// File: tb/ncc_cascade_merge_bench.sv
module ncc_cascade_merge_bench;

   localparam int CLK_P = 10;
   localparam int DW    = 6;

   logic                 clk, rst_n, smp_stb, bit_s1, bit_s2;
   logic [1:0]           mode_sel, cust_rate, cust_bias;
   logic                 cust_order, cust_wide;
   logic signed [DW-1:0] dout;
   logic                 dout_vld, stg1_en, stg2_en, bw_wide;
   logic [2:0]           rate_oh, bias_oh;

   int         n_chk, n_bad;
   logic [5:0] m_cfg;
   int         m_blank, h1a, h1b, h2a, h2b, exp_d;
   logic       exp_v;

   // {mode_sel, bit_s1, bit_s2}
   localparam logic [3:0] VEC [16] = '{
      4'b01_1_1, 4'b01_0_1, 4'b01_1_0, 4'b01_0_0,
      4'b01_1_1, 4'b01_1_1, 4'b01_0_1, 4'b00_1_1,
      4'b00_1_0, 4'b00_0_1, 4'b00_0_1, 4'b10_1_0,
      4'b10_0_0, 4'b10_1_1, 4'b10_0_1, 4'b10_1_0
   };

   ncc_cascade_merge #(.DOUT_W(DW)) u_ncc_cascade_merge (
      .clk, .rst_n, .smp_stb, .bit_s1, .bit_s2, .mode_sel, .cust_order,
      .cust_rate, .cust_wide, .cust_bias, .dout, .dout_vld, .stg1_en,
      .stg2_en, .rate_oh, .bw_wide, .bias_oh
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   function automatic logic [5:0] eff(input logic [1:0] m);
      case (m)
         2'd0:    return 6'b0_00_0_00;
         2'd1:    return 6'b1_01_1_01;
         2'd2:    return 6'b1_10_1_10;
         default: return {cust_order, (cust_rate == 2'd3) ? 2'd2 : cust_rate,
                          cust_wide, (cust_bias == 2'd3) ? 2'd2 : cust_bias};
      endcase
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_ctrl(input string tag);
      chk({tag, " stg1_en"}, int'(stg1_en), int'(m_cfg[5]));
      chk({tag, " stg2_en"}, int'(stg2_en), 1);
      chk({tag, " rate_oh"}, int'(rate_oh), 1 << m_cfg[4:3]);
      chk({tag, " bw_wide"}, int'(bw_wide), int'(m_cfg[2]));
      chk({tag, " bias_oh"}, int'(bias_oh), 1 << m_cfg[1:0]);
   endtask

   // One clock: drive at a falling edge, model, check at the next falling edge.
   task automatic cyc(input logic [1:0] m, input logic s, input logic a, input logic b);
      logic [5:0] nc;
      int y1, y2;
      mode_sel = m; smp_stb = s; bit_s1 = a; bit_s2 = b;
      nc = eff(m);
      exp_v = 1'b0;
      if (nc != m_cfg) begin
         m_cfg = nc; m_blank = 2;
         h1a = 0; h1b = 0; h2a = 0; h2b = 0;
      end else if (s) begin
         y1 = a ? 1 : -1;
         y2 = b ? 1 : -1;
         if (m_cfg[5]) begin
            exp_d = h1b + 5 * (y2 - 2 * h2a + h2b);
            h1b = h1a; h1a = y1; h2b = h2a; h2a = y2;
         end else begin
            exp_d = int'(b);
         end
         if (m_blank > 0) m_blank--;
         else             exp_v = 1'b1;
      end
      @(negedge clk);
      chk("R3/R4 valid", int'(dout_vld), int'(exp_v));
      chk(m_cfg[5] ? "R1/R3 word" : "R2/R3 word", int'(dout), exp_d);
   endtask

   initial begin
      n_chk = 0; n_bad = 0;
      rst_n = 1'b0; smp_stb = 1'b0; bit_s1 = 1'b0; bit_s2 = 1'b0;
      mode_sel = 2'd0; cust_order = 1'b0; cust_rate = 2'd0;
      cust_wide = 1'b0; cust_bias = 2'd0;
      m_cfg = 6'd0; m_blank = 2; exp_d = 0;
      h1a = 0; h1b = 0; h2a = 0; h2b = 0;
      repeat (3) @(negedge clk);

      // R5 reset state
      chk("R5 dout in reset", int'(dout), 0);
      chk("R5 valid in reset", int'(dout_vld), 0);
      chk_ctrl("R5 low-power after reset");
      rst_n = 1'b1;

      // R5 first two strobes blanked
      cyc(2'd0, 1'b1, 1'b1, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 1'b1);
      cyc(2'd0, 1'b1, 1'b1, 1'b1);
      chk("R5 third strobe valid", int'(dout_vld), 1);

      // Vector table walk
      for (int i = 0; i < 16; i++) begin
         cyc(VEC[i][3:2], 1'b1, VEC[i][1], VEC[i][0]);
         cyc(VEC[i][3:2], 1'b0, 1'b0, 1'b0);
      end

      // R1 extremes after a fresh clear
      cyc(2'd2, 1'b0, 1'b0, 1'b0);
      cyc(2'd1, 1'b0, 1'b0, 1'b0);
      cyc(2'd1, 1'b1, 1'b1, 1'b1);
      cyc(2'd1, 1'b1, 1'b0, 1'b0);
      cyc(2'd1, 1'b1, 1'b1, 1'b1);
      chk("R1 maximum word", int'(dout), 21);
      cyc(2'd1, 1'b1, 1'b0, 1'b0);
      chk("R1 minimum word", int'(dout), -21);

      // R4 change coincident with a strobe
      cyc(2'd2, 1'b1, 1'b1, 1'b1);
      chk("R4 strobe dropped on change", int'(dout_vld), 0);
      chk("R4 word held on change", int'(dout), -21);
      cyc(2'd2, 1'b1, 1'b1, 1'b0);
      chk("R4 blank one", int'(dout_vld), 0);
      cyc(2'd2, 1'b1, 1'b0, 1'b1);
      chk("R4 blank two", int'(dout_vld), 0);
      cyc(2'd2, 1'b1, 1'b1, 1'b1);
      chk("R4 valid again", int'(dout_vld), 1);

      // R8 equivalent custom set, strobe in the same cycle
      cyc(2'd1, 1'b0, 1'b0, 1'b0);
      repeat (3) cyc(2'd1, 1'b1, 1'b1, 1'b0);
      cust_order = 1'b1; cust_rate = 2'd1; cust_wide = 1'b1; cust_bias = 2'd1;
      cyc(2'd3, 1'b1, 1'b1, 1'b0);
      chk("R8 no blank on equal config", int'(dout_vld), 1);

      // R6 presets
      cyc(2'd0, 1'b0, 1'b0, 1'b0);
      chk_ctrl("R6 low-power");
      chk("R6 low rate_oh", int'(rate_oh), 1);
      cyc(2'd1, 1'b0, 1'b0, 1'b0);
      chk_ctrl("R6 standard");
      chk("R6 std bias_oh", int'(bias_oh), 2);
      cyc(2'd2, 1'b0, 1'b0, 1'b0);
      chk_ctrl("R6 high-res");
      chk("R6 hires rate_oh", int'(rate_oh), 4);

      // R7 custom codes
      cust_order = 1'b0; cust_rate = 2'd3; cust_wide = 1'b0; cust_bias = 2'd3;
      cyc(2'd3, 1'b0, 1'b0, 1'b0);
      chk("R7 rate code 3", int'(rate_oh), 4);
      chk("R7 bias code 3", int'(bias_oh), 4);
      chk("R7 second order", int'(stg1_en), 0);
      cust_order = 1'b1; cust_rate = 2'd1; cust_wide = 1'b1; cust_bias = 2'd0;
      cyc(2'd3, 1'b0, 1'b0, 1'b0);
      chk_ctrl("R7 custom mix");
      chk("R7 rate code 1", int'(rate_oh), 2);

      // R2 pass-through
      cyc(2'd0, 1'b0, 1'b0, 1'b0);
      cyc(2'd0, 1'b1, 1'b0, 1'b0);
      cyc(2'd0, 1'b1, 1'b1, 1'b1);
      cyc(2'd0, 1'b1, 1'b0, 1'b1);
      chk("R2 bit one", int'(dout), 1);
      cyc(2'd0, 1'b1, 1'b1, 1'b0);
      chk("R2 bit zero", int'(dout), 0);

      // Random streams in both orders with occasional mode moves
      for (int i = 0; i < 800; i++) begin
         logic [1:0] m;
         m = (i % 100 < 50) ? 2'd1 : 2'd0;
         if (i % 100 == 75) m = 2'd2;
         cyc(m, ($urandom % 3) != 0, 1'($urandom), 1'($urandom));
      end

      smp_stb = 1'b0;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule